// File: doc/BRIEF.md
# Bidirectional AES-128 Round-Key Generator

This block supplies AES-128 round keys to a word-serial cipher datapath one round at a time. It holds only the current 128-bit round key, as four 32-bit words, and derives each new key from the one it holds. It never keeps the full forty-four-word expansion. A load pulse captures a cipher key and a direction. For encryption the generator starts at round 0 and steps forward on each request. For decryption it first runs a setup pass of ten internal forward steps to reach the round-10 key. It then steps backward on request and delivers the keys in descending order.

The substitution box is computed from a GF(2^8) inverse followed by the affine map. One round-constant function serves both directions. The control logic picks its index from the current round number: the index is r for the step from round r to r+1, and r-1 for the step from round r to r-1. The cipher controller sees the current key, its round number and a ready flag. The ready flag stays low while the decryption setup is in progress.

Top module: `keyexp_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `round_key` is all zeros, `round_idx` is 0, `ready` is 1 and the direction is encryption.
- R2: A `load` sampled with `decrypt`=0 makes `round_key` equal `key_in`, `round_idx` 0 and `ready` 1 in the next cycle.
- R3: A `load` sampled with `decrypt`=1 drives `ready` low for exactly 10 cycles, starting the cycle after the load edge. When `ready` returns high, `round_key` is the round-10 key of `key_in` and `round_idx` is 10.
- R4: In encryption mode with `ready` high and `round_idx` < 10, a `step` replaces the key words k0..k3 (k0 in bits 127:96) by n0=k0^T, n1=k1^n0, n2=k2^n1, n3=k3^n2. Here T = SubWord(RotWord(k3)) ^ {rcon[round_idx], 24'h0}. `round_idx` rises by 1.
- R5: In decryption mode with `ready` high and `round_idx` > 0, a `step` replaces the key by the key of the previous round, that is, the key whose forward step yields the current one. `round_idx` falls by 1.
- R6: A `step` at the end of the range has no effect on `round_key` or `round_idx`. The end of the range is `round_idx`=10 when encrypting and `round_idx`=0 when decrypting.
- R7: A `step` that arrives while `ready` is low is ignored. The setup pass still finishes on schedule with the round-10 key and does not move past it.
- R8: The round constants for indices 0 to 9 are 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36. The last round key of the all-zero cipher key and of two further test keys match their published values.
- R9: `load` takes priority over `step` and over a setup in progress. It restarts the generator from the new key and the new direction.
- R10: With no `load` and no accepted `step`, and outside setup, `round_key` and `round_idx` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture `key_in` and `decrypt`, restart at round 0 |
| decrypt | input | 1 | Direction sampled at load: 1 = decryption order |
| key_in | input | 128 | Cipher key, first word in bits 127:96 |
| step | input | 1 | Request the next round key in the current direction |
| round_key | output | 128 | Current round key, first word in bits 127:96 |
| round_idx | output | 4 | Round number of `round_key`, 0 to 10 |
| ready | output | 1 | Low while the decryption setup pass runs |

## Verification
The hardest situation to reach is a request that overlaps the decryption setup. The bench holds `step` high through every setup cycle and through the edge where `ready` rises. This shows that the setup ends on the round-10 key rather than one round further. A second setup is cut off midway by a new encryption load issued together with a step. This shows that load priority holds even while the internal pass is busy. Every forward key is also checked to reverse back to the key before it.

// File: rtl/keyexp_pkg.sv
`timescale 1ns/1ps
package keyexp_pkg;
  localparam int WORD_W = 32;
  localparam int KEY_W  = 4 * WORD_W;

  function automatic logic [7:0] kx_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] kx_gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, aa;
    p  = 8'h00;
    aa = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ aa;
      aa = kx_xtime(aa);
    end
    return p;
  endfunction

  // a^254 by repeated squaring; maps 0 to 0
  function automatic logic [7:0] kx_ginv(input logic [7:0] a);
    logic [7:0] sq, r;
    sq = a;
    r  = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq = kx_gmul(sq, sq);
      r  = kx_gmul(r, sq);
    end
    return r;
  endfunction

  function automatic logic [7:0] kx_sbox(input logic [7:0] a);
    logic [7:0] b;
    b = kx_ginv(a);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [7:0] kx_rcon(input logic [7:0] idx);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 0; i < 16; i++)
      if (8'(i) < idx) r = kx_xtime(r);
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] kx_rotword(input logic [WORD_W-1:0] w);
    return {w[WORD_W-9:0], w[WORD_W-1:WORD_W-8]};
  endfunction
endpackage

// File: rtl/keyexp_subword.sv
`timescale 1ns/1ps
module keyexp_subword
  import keyexp_pkg::*;
(
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  localparam int NBYTES = WORD_W / 8;
  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign dout[8*g +: 8] = kx_sbox(din[8*g +: 8]);
  end
endmodule

// File: rtl/keyexp_fwd.sv
`timescale 1ns/1ps
module keyexp_fwd
  import keyexp_pkg::*;
(
  input  logic [KEY_W-1:0] cur,
  input  logic [7:0]       rc,
  output logic [KEY_W-1:0] nxt
);
  logic [WORD_W-1:0] k0, k1, k2, k3, sw, t, n0, n1, n2, n3;
  assign {k0, k1, k2, k3} = cur;

  keyexp_subword u_sw (.din(kx_rotword(k3)), .dout(sw));

  assign t  = sw ^ {rc, {(WORD_W-8){1'b0}}};
  assign n0 = k0 ^ t;
  assign n1 = k1 ^ n0;
  assign n2 = k2 ^ n1;
  assign n3 = k3 ^ n2;
  assign nxt = {n0, n1, n2, n3};
endmodule

// File: rtl/keyexp_rev.sv
`timescale 1ns/1ps
module keyexp_rev
  import keyexp_pkg::*;
(
  input  logic [KEY_W-1:0] cur,
  input  logic [7:0]       rc,
  output logic [KEY_W-1:0] prv
);
  logic [WORD_W-1:0] k0, k1, k2, k3, p0, p1, p2, p3, sw;
  assign {k0, k1, k2, k3} = cur;

  // words 3..1 come from neighbour XORs, word 0 needs the rebuilt word 3
  assign p3 = k3 ^ k2;
  assign p2 = k2 ^ k1;
  assign p1 = k1 ^ k0;

  keyexp_subword u_sw (.din(kx_rotword(p3)), .dout(sw));

  assign p0  = k0 ^ sw ^ {rc, {(WORD_W-8){1'b0}}};
  assign prv = {p0, p1, p2, p3};
endmodule

// File: rtl/keyexp_top.sv
`timescale 1ns/1ps
module keyexp_top
  import keyexp_pkg::*;
#(
  parameter int ROUNDS = 10,
  localparam int RW = $clog2(ROUNDS + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             decrypt,
  input  logic [KEY_W-1:0] key_in,
  input  logic             step,
  output logic [KEY_W-1:0] round_key,
  output logic [RW-1:0]    round_idx,
  output logic             ready
);
  localparam logic [RW-1:0] LAST = RW'(ROUNDS);

  logic [KEY_W-1:0] key_q, fwd_key, rev_key, chk_back;
  logic [RW-1:0]    round_q;
  logic             dec_q, busy_q;
  logic [7:0]       rc_fwd, rc_rev;
  logic             fwd_go, rev_go, setup_adv, setup_last;

  // Named events for the checks below
  assign rc_fwd     = kx_rcon(8'(round_q));
  assign rc_rev     = kx_rcon(8'(round_q - RW'(1)));
  assign fwd_go     = step && !busy_q && !dec_q && (round_q != LAST);
  assign rev_go     = step && !busy_q && dec_q && (round_q != '0);
  assign setup_adv  = busy_q;
  assign setup_last = busy_q && (round_q == LAST - RW'(1));

  keyexp_fwd u_fwd (.cur(key_q), .rc(rc_fwd), .nxt(fwd_key));
  keyexp_rev u_rev (.cur(key_q), .rc(rc_rev), .prv(rev_key));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q   <= '0;
      round_q <= '0;
      dec_q   <= 1'b0;
      busy_q  <= 1'b0;
    end else if (load) begin
      key_q   <= key_in;
      round_q <= '0;
      dec_q   <= decrypt;
      busy_q  <= decrypt;
    end else if (setup_adv || fwd_go) begin
      key_q   <= fwd_key;
      round_q <= round_q + RW'(1);
      if (setup_last) busy_q <= 1'b0;
    end else if (rev_go) begin
      key_q   <= rev_key;
      round_q <= round_q - RW'(1);
    end
  end

  assign round_key = key_q;
  assign round_idx = round_q;
  assign ready     = !busy_q;

  // Independent reverse path fed by the forward result: must give back the held key
  keyexp_rev u_chk (.cur(fwd_key), .rc(rc_fwd), .prv(chk_back));

  p_round_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    round_q <= LAST);

  p_enc_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_go && !load) |=> (round_q == $past(round_q) + RW'(1)) && (key_q == $past(fwd_key)));

  p_dec_retreat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rev_go && !load) |=> round_q == $past(round_q) - RW'(1));

  p_setup_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_last && !load) |=> ready && (round_q == LAST));

  p_inverse_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_back == key_q);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !busy_q && !fwd_go && !rev_go) |=> $stable(key_q) && $stable(round_q));

  p_load_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (round_q == '0) && (key_q == $past(key_in)));
endmodule

// File: tb/keyexp_top_bench.sv
`timescale 1ns/1ps
module keyexp_top_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic         decrypt = 1'b0;
  logic [127:0] key_in = '0;
  logic         step = 1'b0;
  logic [127:0] round_key;
  logic [3:0]   round_idx;
  logic         ready;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  keyexp_top u_keyexp_top (
    .clk(clk), .rst_n(rst_n), .load(load), .decrypt(decrypt), .key_in(key_in),
    .step(step), .round_key(round_key), .round_idx(round_idx), .ready(ready)
  );

  // R8 round constants
  localparam logic [7:0] RC [10] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10,
                                     8'h20, 8'h40, 8'h80, 8'h1b, 8'h36};
  // cipher key, published round-10 key (R8)
  localparam logic [255:0] VEC [3] = '{
    {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6},
    {128'h00000000000000000000000000000000, 128'hb4ef5bcb3e92e21123e951cf6f8f188e},
    {128'h000102030405060708090a0b0c0d0e0f, 128'h13111d7fe3944a17f307a78b4d2b30c5}
  };

  logic [127:0] ek [0:10];
  logic [31:0]  w  [0:43];

  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] m_sb(input logic [7:0] x);
    logic [7:0] v, s;
    v = 8'h00;
    for (int y = 1; y < 256; y++) if (m_mul(x, 8'(y)) == 8'h01) v = 8'(y);
    for (int i = 0; i < 8; i++)
      s[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8] ^ ((8'h63 >> i) & 8'h01) != 0;
    return s;
  endfunction

  task automatic build(input logic [127:0] k);
    logic [31:0] t;
    {w[0], w[1], w[2], w[3]} = k;
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0)
        t = {m_sb(t[23:16]) ^ RC[i/4-1], m_sb(t[15:8]), m_sb(t[7:0]), m_sb(t[31:24])};
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r <= 10; r++) ek[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_load(input logic [127:0] k, input logic dir, input logic stp);
    key_in = k; decrypt = dir; load = 1'b1; step = stp;
    tick();
    load = 1'b0; step = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    chk("R1 reset key", round_key, '0);
    tick(); tick();
    rst_n = 1'b1;
    chk("R1 reset idx/ready", {round_idx, ready}, {4'd0, 1'b1});
    tick();
    chk("R1 after reset", {round_key[3:0], round_idx, ready}, {4'h0, 4'd0, 1'b1});

    // R4 step right after reset works on the all-zero key in encryption mode
    build('0);
    step = 1'b1; tick(); step = 1'b0;
    chk("R4 step from reset", round_key, ek[1]);

    for (int v = 0; v < 3; v++) begin
      build(VEC[v][255:128]);
      do_load(VEC[v][255:128], 1'b0, 1'b0);
      chk("R2 enc load key", round_key, VEC[v][255:128]);
      chk("R2 enc load idx/ready", {round_idx, ready}, {4'd0, 1'b1});
      for (int r = 1; r <= 10; r++) begin
        step = 1'b1; tick(); step = 1'b0;
        chk("R4 enc step key", round_key, ek[r]);
        chk("R4 enc step idx", 128'(round_idx), 128'(r));
      end
      chk("R8 published last key", round_key, VEC[v][127:0]);
      step = 1'b1; tick(); step = 1'b0;
      chk("R6 enc step at end", {round_key, round_idx}, {ek[10], 4'd10});
      tick(); tick();
      chk("R10 idle hold", {round_key, round_idx}, {ek[10], 4'd10});

      // decryption: step held high through all of setup (R7)
      key_in = VEC[v][255:128]; decrypt = 1'b1; load = 1'b1;
      tick();
      load = 1'b0; step = 1'b1;
      chk("R3 ready low after load", 128'(ready), 128'(0));
      for (int c = 1; c < 10; c++) begin
        tick();
        chk("R3 ready low in setup", 128'(ready), 128'(0));
      end
      tick();
      step = 1'b0;
      chk("R3 ready back", 128'(ready), 128'(1));
      chk("R7 setup ends at last key", {round_key, round_idx}, {ek[10], 4'd10});
      for (int r = 9; r >= 0; r--) begin
        step = 1'b1; tick(); step = 1'b0;
        chk("R5 dec step key", round_key, ek[r]);
        chk("R5 dec step idx", 128'(round_idx), 128'(r));
      end
      step = 1'b1; tick(); step = 1'b0;
      chk("R6 dec step at zero", {round_key, round_idx}, {ek[0], 4'd0});
    end

    // R9 load with step during a setup in progress
    do_load(VEC[0][255:128], 1'b1, 1'b0);
    tick(); tick(); tick();
    chk("R9 mid setup busy", 128'(ready), 128'(0));
    do_load(VEC[2][255:128], 1'b0, 1'b1);
    chk("R9 load overrides setup", {round_key, round_idx, ready}, {VEC[2][255:128], 4'd0, 1'b1});
    tick();
    chk("R10 no step no change", {round_key, round_idx}, {VEC[2][255:128], 4'd0});
    build(VEC[2][255:128]);
    step = 1'b1; tick(); step = 1'b0;
    chk("R4 step after override", round_key, ek[1]);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog R1-run: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule